// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a host-side master for a 12-bit successive-approximation converter that has a three-wire serial port: a chip-select it drives low, a serial clock it drives, and one data line it receives. Running on the system clock, it derives the serial clock from a parameterised divider. Each read is framed by chip-select. The block collects the result bits, keeps a quiet interval before the next frame may begin, and hands the 12-bit code to the consumer on a valid/ready pair.

A one-cycle `start_i` pulse requests a transfer. When `pdown_i` is high at that moment, the block runs a short frame instead. In that frame chip-select rises inside the window that puts the converter into shutdown. The next normal start wakes the converter with a throw-away frame and then runs a second frame whose result is reported. The converter's state after power-up is unknown, so the first read after reset is handled the same way.

Top module: `sar_adc_reader`

## Requirements
- R1: After reset, `cs_no` and `sclk_o` are high, and `valid_o` and `busy_o` are low.
- R2: A start that is accepted drives `cs_no` low. A normal frame then gives exactly 16 falling edges on `sclk_o`. `cs_no` rises only after `sclk_o` has returned high following the 16th fall.
- R3: Inside a frame, each low phase and each high phase of `sclk_o` lasts `HALF_DIV` system clocks, which gives a 50% duty cycle. Whenever `cs_no` is high, `sclk_o` is high.
- R4: `sdata_i` is sampled on the system clock edge that drives `sclk_o` low. The bit taken at the 1st fall is discarded. The bits taken at falls 2 to 4 are the three leading bits. Falls 5 to 16 give `data_o[11]` down to `data_o[0]`, most significant bit first.
- R5: `err_o` is 1 when any of the three leading bits was received as 1. The 12 data bits are still reported.
- R6: Between `cs_no` rising and the next fall, `cs_no` stays high for at least `QUIET_CYC` system clocks. Two frames run back to back from one start are separated by exactly `QUIET_CYC` clocks, and that must be at least four serial clock periods.
- R7: After reset, and after any power-down frame, a normal start runs two frames. The first result is dropped and only the second is reported. While the converter is awake, a start runs a single frame.
- R8: A start with `pdown_i` high runs a frame in which `cs_no` rises after the high phase that follows fall `PD_FALLS`, where `PD_FALLS` lies between 2 and 9. Such a frame reports no result.
- R9: Once `valid_o` is high, it stays high, and `data_o` and `err_o` stay stable, until a clock edge with `ready_i` high. `start_i` is ignored while `busy_o` or `valid_o` is high.
- R10: `busy_o` is high from the clock after an accepted start until the last quiet interval ends. It is low otherwise, and `cs_no` is high whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle transfer request |
| pdown_i | input | 1 | With start_i: run a shutdown frame |
| ready_i | input | 1 | Consumer accepts the result |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_no | output | 1 | Active-low chip select |
| busy_o | output | 1 | A frame or quiet interval is in progress |
| valid_o | output | 1 | Result available |
| data_o | output | DATA_W | Conversion code |
| err_o | output | 1 | A leading bit was received as 1 |

## Verification
The converter model in the bench changes bits only on serial clock falls. It returns all ones, including the leading bits, for any frame that starts while it is asleep. A dummy frame that is wrongly reported therefore shows up as a data mismatch. Results of all zeros, all ones, alternating patterns and a lone low bit separate bit order, off-by-one sampling and stuck bits. An injected leading one separates error flagging from data corruption. Power-down followed by wake-up, and a result held back by low ready, show whether the frame count, the edge count and the hold behaviour follow the requested sequence.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } rd_state_e;
endpackage

// File: rtl/sar_sclk_tick.sv
module sar_sclk_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF_DIV == 1) begin : g_every
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (!run_i)          cnt_q <= '0;
        else if (cnt_q == LAST)   cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift #(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              lead_err_o
);
  localparam int SH_W = DATA_W + LEAD_W;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (cap_i) sh_q <= {sh_q[SH_W-2:0], bit_i};
  end

  assign data_o     = sh_q[DATA_W-1:0];
  assign lead_err_o = |sh_q[SH_W-1:DATA_W];
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int HALF_DIV  = 3,
  parameter int QUIET_CYC = 24,
  parameter int PD_FALLS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pdown_i,
  input  logic              ready_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  localparam int LEAD_W      = 3;
  localparam int FRAME_FALLS = DATA_W + LEAD_W + 1;
  localparam int FC_W        = $clog2(FRAME_FALLS + 1);
  localparam int QC_W        = $clog2(QUIET_CYC + 1);
  localparam logic [FC_W-1:0] END_NORM = FC_W'(FRAME_FALLS);
  localparam logic [FC_W-1:0] END_PD   = FC_W'(PD_FALLS);
  localparam logic [QC_W-1:0] Q_LAST   = QC_W'(QUIET_CYC - 1);

  rd_state_e         st_q;
  logic              sclk_q, cs_q;
  logic              pd_q, dummy_q, pend_q, need_dummy_q;
  logic [FC_W-1:0]   fall_cnt_q;
  logic [QC_W-1:0]   qcnt_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q, valid_q;

  logic              tick, cap, accept;
  logic [FC_W-1:0]   end_cnt;
  logic [DATA_W-1:0] rx_data;
  logic              rx_err;

  sar_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == ST_FRAME),
    .tick_o(tick)
  );

  assign end_cnt = pd_q ? END_PD : END_NORM;
  assign accept  = (st_q == ST_IDLE) && start_i && !valid_q;
  // capture on the edge that drives SCLK low, skipping the first fall
  assign cap = tick && (st_q == ST_FRAME) && sclk_q &&
               (fall_cnt_q != end_cnt) && (fall_cnt_q != '0);

  sar_rx_shift #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .bit_i     (sdata_i),
    .data_o    (rx_data),
    .lead_err_o(rx_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      sclk_q       <= 1'b1;
      cs_q         <= 1'b1;
      pd_q         <= 1'b0;
      dummy_q      <= 1'b0;
      pend_q       <= 1'b0;
      need_dummy_q <= 1'b1;
      fall_cnt_q   <= '0;
      qcnt_q       <= '0;
      data_q       <= '0;
      err_q        <= 1'b0;
      valid_q      <= 1'b0;
    end else begin
      if (valid_q && ready_i) valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q       <= ST_FRAME;
            cs_q       <= 1'b0;
            sclk_q     <= 1'b1;
            fall_cnt_q <= '0;
            pd_q       <= pdown_i;
            dummy_q    <= !pdown_i && need_dummy_q;
          end
        end
        ST_FRAME: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else if (fall_cnt_q == end_cnt) begin
              cs_q   <= 1'b1;
              st_q   <= ST_QUIET;
              qcnt_q <= '0;
              if (pd_q) begin
                need_dummy_q <= 1'b1;
                pend_q       <= 1'b0;
              end else if (dummy_q) begin
                need_dummy_q <= 1'b0;
                pend_q       <= 1'b1;
              end else begin
                data_q  <= rx_data;
                err_q   <= rx_err;
                valid_q <= 1'b1;
                pend_q  <= 1'b0;
              end
            end else begin
              sclk_q     <= 1'b0;
              fall_cnt_q <= fall_cnt_q + 1'b1;
            end
          end
        end
        ST_QUIET: begin
          if (qcnt_q == Q_LAST) begin
            if (pend_q) begin
              st_q       <= ST_FRAME;
              cs_q       <= 1'b0;
              sclk_q     <= 1'b1;
              fall_cnt_q <= '0;
              pd_q       <= 1'b0;
              dummy_q    <= 1'b0;
              pend_q     <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end else begin
            qcnt_q <= qcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_q;
  assign cs_no   = cs_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign err_o   = err_q;

  // independent count of SCLK falls seen at the pins
  logic            sclk_d;
  logic [FC_W-1:0] chk_falls;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d    <= 1'b1;
      chk_falls <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_no)                 chk_falls <= '0;
      else if (sclk_d && !sclk_o) chk_falls <= chk_falls + 1'b1;
    end
  end

  assert_fall_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (chk_falls == END_NORM || chk_falls == END_PD));

  assert_sclk_park_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(err_o)));

  assert_cs_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  assert_no_start_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !busy_o) |=> !busy_o);
endmodule

// File: tb/sar_adc_reader_bench.sv
module sar_adc_reader_bench;
  localparam int DATA_W    = 12;
  localparam int HALF_DIV  = 3;
  localparam int QUIET_CYC = 24;
  localparam int PD_FALLS  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, pdown_i = 1'b0, ready_i = 1'b1, sdata_i = 1'b0;
  logic sclk_o, cs_no, busy_o, valid_o, err_o;
  logic [DATA_W-1:0] data_o;

  always #5 clk = ~clk;

  sar_adc_reader #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC),
                   .PD_FALLS(PD_FALLS)) u_sar_adc_reader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pdown_i(pdown_i),
    .ready_i(ready_i), .sdata_i(sdata_i), .sclk_o(sclk_o), .cs_no(cs_no),
    .busy_o(busy_o), .valid_o(valid_o), .data_o(data_o), .err_o(err_o)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  bit asleep = 1'b1;
  bit fr_sleep = 1'b0;
  int falls = 0, last_falls = 0, nframes = 0;
  logic [11:0] next_val = '0, cur_val = '0;
  bit inj_err = 1'b0, cur_err = 1'b0;

  function automatic logic bitf(input int p);
    if (fr_sleep) return 1'b1;
    if (p >= 1 && p <= 3) return (cur_err && p == 2);
    if (p >= 4 && p <= 15) return cur_val[15-p];
    return 1'b0;
  endfunction

  always @(negedge cs_no) begin
    falls = 0;
    fr_sleep = asleep;
    cur_val = next_val;
    cur_err = inj_err;
    #1 sdata_i = bitf(0);
  end

  always @(negedge sclk_o) begin
    if (!cs_no) begin
      falls++;
      #1 sdata_i = bitf(falls);
    end
  end

  always @(posedge cs_no) begin
    if (rst_ni) begin
      last_falls = falls;
      nframes++;
      if (falls >= 10) asleep = 1'b0;
      else if (falls >= 2) asleep = 1'b1;
    end
  end

  // ---------------- pin timing monitor ----------------
  int gap = 0, last_gap = 0, tail = 0, run = 0, min_run = 1000, max_run = 0;
  bit prev_cs = 1'b1, prev_s = 1'b1;
  always @(negedge clk) begin
    if (cs_no) begin
      gap++;
      if (busy_o) tail++;
    end else begin
      if (prev_cs) begin
        last_gap = gap;
        run = 1;
        prev_s = sclk_o;
        tail = 0;
      end else if (sclk_o == prev_s) begin
        run++;
      end else begin
        if (run < min_run) min_run = run;
        if (run > max_run) max_run = run;
        run = 1;
        prev_s = sclk_o;
      end
      gap = 0;
    end
    prev_cs = cs_no;
  end

  // ---------------- scoreboard ----------------
  logic [12:0] exp_q[$];
  always @(negedge clk) begin
    if (rst_ni && valid_o && ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R8 unexpected result", int'({err_o, data_o}), 0);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk({err_o, data_o} == e, "R4/R5 result", int'({err_o, data_o}), int'(e));
      end
    end
  end

  task automatic pulse_start(input bit pd);
    @(posedge clk); #1 start_i = 1'b1; pdown_i = pd;
    @(posedge clk); #1 start_i = 1'b0; pdown_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, "R10 busy timeout", n, 0);
  endtask

  task automatic do_read(input logic [11:0] v, input bit e, input int exp_frames);
    int f0 = nframes;
    next_val = v;
    inj_err = e;
    min_run = 1000;
    max_run = 0;
    exp_q.push_back({e, v});
    pulse_start(1'b0);
    @(negedge clk);
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(nframes - f0 == exp_frames, "R7 frame count", nframes - f0, exp_frames);
    chk(last_falls == 16, "R2 falls per frame", last_falls, 16);
    chk(min_run == HALF_DIV && max_run == HALF_DIV, "R3 phase length", min_run, HALF_DIV);
    chk(tail == QUIET_CYC, "R6/R10 busy through quiet", tail, QUIET_CYC);
    chk(exp_q.size() == 0, "R4 result delivered", exp_q.size(), 0);
    inj_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(cs_no == 1'b1, "R1 cs_no reset", cs_no, 1);
    chk(sclk_o == 1'b1, "R1 sclk_o reset", sclk_o, 1);
    chk(valid_o == 1'b0, "R1 valid_o reset", valid_o, 0);
    chk(busy_o == 1'b0, "R1 busy_o reset", busy_o, 0);

    // R7: first read after reset wakes the converter
    do_read(12'h5A3, 1'b0, 2);
    chk(last_gap == QUIET_CYC, "R6 back-to-back gap", last_gap, QUIET_CYC);
    chk(last_gap >= 8 * HALF_DIV, "R6 gap >= 4 SCLK", last_gap, 8 * HALF_DIV);

    // R4: patterns while awake, single frame each
    do_read(12'h000, 1'b0, 1);
    do_read(12'hFFF, 1'b0, 1);
    do_read(12'hAAA, 1'b0, 1);
    do_read(12'hFFE, 1'b0, 1);
    do_read(12'h001, 1'b0, 1);

    // R5: leading one flagged, data kept
    do_read(12'h3C7, 1'b1, 1);

    // R8: power-down frame
    pulse_start(1'b1);
    wait_idle();
    chk(last_falls == PD_FALLS, "R8 falls in pd frame", last_falls, PD_FALLS);
    chk(asleep == 1'b1, "R8 converter asleep", asleep, 1);
    begin
      bit seen = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (valid_o) seen = 1'b1;
      end
      chk(seen == 1'b0, "R8 no result", seen, 0);
    end

    // R7: wake-up drops the dummy
    do_read(12'h8E1, 1'b0, 2);
    chk(last_gap == QUIET_CYC, "R6 wake gap", last_gap, QUIET_CYC);

    // R9: hold until ready, start ignored while pending
    @(posedge clk); #1 ready_i = 1'b0;
    next_val = 12'h47D;
    exp_q.push_back({1'b0, 12'h47D});
    pulse_start(1'b0);
    wait_idle();
    chk(valid_o == 1'b1, "R9 valid raised", valid_o, 1);
    chk(data_o == 12'h47D, "R9 data", data_o, 12'h47D);
    repeat (10) @(negedge clk);
    chk(valid_o == 1'b1 && data_o == 12'h47D, "R9 held", data_o, 12'h47D);
    pulse_start(1'b0);
    begin
      bit moved = 1'b0;
      repeat (6) begin
        @(negedge clk);
        if (!cs_no || busy_o) moved = 1'b1;
      end
      chk(moved == 1'b0, "R9 start ignored while valid", moved, 0);
    end
    @(posedge clk); #1 ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R9 valid cleared", valid_o, 0);
    chk(exp_q.size() == 0, "R9 result taken", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule